// File: doc/BRIEF.md
# Synchronous Burst Memory Front-End

This block sits between the pins of a 32-bit memory and its storage array. It decodes active-low chip select, output enable, output disable, write enable, address load, read/write select and burst step inputs. From them it produces a registered array read address, a registered write strobe with its address and data, a read strobe, and a drive enable with data for the data bus. The storage array is outside the block: it returns the word at the read address on `rdata`, and it accepts writes when `arr_we` is high.

A configuration bit chooses one of two modes. In asynchronous mode an access follows the pins. The read address is taken when a read cycle opens, and output disable cuts the bus at once. In synchronous burst mode the start address is loaded on a clock edge and tagged as a read or a write burst. It then steps under pin control inside an aligned window of 4 or 8 words, and it can be held for any number of cycles. Output enable and output disable are sampled on the clock, and they act one edge later. A second configuration bit chooses the window length.

Reset/power-down is a synchronous active-high input. While it is high the bus is released and no access is accepted. When it is released the block is always in asynchronous read mode with a 4-word window.

Top module: `burst_mem_front`

## Requirements
- R1: While `pd_rst` is high at a rising edge, the outputs after that edge are `dq_oe`=0, `arr_we`=0, `arr_rd`=0 and `arr_addr`=0. `dq_oe` is also 0 during the cycle in which `pd_rst` is high. After release the mode is asynchronous and the window is 4 words.
- R2: In synchronous mode, when `cs_n`=0 and `load_n`=0 at an edge, `arr_addr` becomes `addr_in`. The burst is a read if `rd_sel`=1 and a write if `rd_sel`=0.
- R3: In synchronous mode, when `cs_n`=0, `load_n`=1 and `step_n`=0 at an edge with a burst open, the address steps by one. Only the low 2 bits (window 4) or the low 3 bits (window 8) change, and the step wraps inside the aligned window. With `step_n`=1 the address holds.
- R4: In a synchronous read burst, if `cs_n`=0, `rd_en_n`=0 and `hiz_n`=1 at edge k, then after edge k `dq_oe`=1 and `dq_out` is the array word at the burst address that held before edge k. `arr_rd` is 1 after edge k.
- R5: In synchronous mode, if `hiz_n`=0 at an edge, `dq_oe` is 0 after that edge, whatever `rd_en_n` is.
- R6: In asynchronous mode `dq_oe` = !`cs_n` & !`rd_en_n` & `hiz_n` & `wen_n` at all times. A low `hiz_n` releases the bus in the same cycle. While the bus is driven, `dq_out` is the word at `arr_addr`.
- R7: With `cs_n`=1 at an edge there is no address load, no step, no write and no read strobe.
- R8: In a synchronous write burst, with `cs_n`=0, `wen_n`=0 and `load_n`=1 at an edge, `arr_we` becomes 1 after that edge. At the same time `arr_waddr` becomes the burst address before the edge and `arr_wdata` becomes `wdata`.
- R9: In asynchronous mode a read cycle opens on the first edge with `cs_n`=0 and `wen_n`=1 after an edge with `cs_n`=1. It also opens on a 1-to-0 change of `load_n` seen on consecutive edges. An open cycle latches `addr_in`. Otherwise `load_n` and `addr_in` leave `arr_addr` unchanged.
- R10: `cfg_we`=1 at an edge loads the mode from `cfg_sync` (1 = synchronous) and the window from `cfg_wrap8` (1 = 8 words). It closes any open burst, and no access takes place on that edge.
- R11: In asynchronous mode, `cs_n`=0 and `wen_n`=0 at an edge give `arr_we`=1 after it, with `arr_waddr`=`addr_in` and `arr_wdata`=`wdata`. `arr_rd` follows `cs_n`=0 with `wen_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| pd_rst | input | 1 | Synchronous reset/power-down, active high |
| cfg_we | input | 1 | Load the mode configuration bits |
| cfg_sync | input | 1 | Mode to load: 1 synchronous, 0 asynchronous |
| cfg_wrap8 | input | 1 | Window to load: 1 eight words, 0 four words |
| cs_n | input | 1 | Chip select, active low |
| rd_en_n | input | 1 | Output enable, active low |
| hiz_n | input | 1 | Output disable, active low, has priority |
| wen_n | input | 1 | Write enable, active low |
| load_n | input | 1 | Burst start address load, active low |
| rd_sel | input | 1 | Burst type at load: 1 read, 0 write |
| step_n | input | 1 | Burst address step, active low |
| addr_in | input | AW | Address from the pins |
| wdata | input | DW | Write data from the pins |
| rdata | input | DW | Word returned by the array at `arr_addr` |
| arr_addr | output | AW | Array read address |
| arr_rd | output | 1 | Read strobe |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | AW | Array write address |
| arr_wdata | output | DW | Array write data |
| dq_oe | output | 1 | Data bus drive enable |
| dq_out | output | DW | Data to drive on the bus |

## Verification
A reference model runs in step with the block under long random pin streams in both modes. Load, step and select are biased active so that bursts form, wrap and pause. Rare configuration writes and resets are mixed in, so that mode changes cut bursts at any point. Directed sequences set the cases apart. A step that crosses the top of a 4-word window is set against the same crossing of an 8-word window. A held step is set against a live one. Output disable is tested alone and together with output enable, in each mode, which separates the immediate release from the one-edge-late one. An address change with no load fall is set against one with a fall, which separates an ignored load from a new asynchronous read cycle.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
  typedef enum logic {
    CYC_READ  = 1'b0,
    CYC_WRITE = 1'b1
  } cyc_e;
endpackage

// File: rtl/bmf_addr_gen.sv
module bmf_addr_gen #(
  parameter int AW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_sync,
  input  logic           wrap8,
  input  logic           cfg_we,
  input  logic           cs_n,
  input  logic           wen_n,
  input  logic           load_n,
  input  logic           rd_sel,
  input  logic           step_n,
  input  logic [AW-1:0]  addr_in,
  output logic [AW-1:0]  baddr,
  output logic           act,
  output bmf_pkg::cyc_e  cyc
);
  import bmf_pkg::*;

  localparam logic [AW-1:0] MASK4 = AW'(3);
  localparam logic [AW-1:0] MASK8 = AW'(7);

  logic          cs_prev_n;
  logic          load_prev_n;
  logic [AW-1:0] mask;
  logic [AW-1:0] stepped;
  logic          new_rd;

  assign mask    = wrap8 ? MASK8 : MASK4;
  assign stepped = (baddr & ~mask) | ((baddr + AW'(1)) & mask);
  assign new_rd  = !cs_n && wen_n && (cs_prev_n || (load_prev_n && !load_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      baddr       <= '0;
      act         <= 1'b0;
      cyc         <= CYC_READ;
      cs_prev_n   <= 1'b1;
      load_prev_n <= 1'b1;
    end else begin
      cs_prev_n   <= cs_n;
      load_prev_n <= load_n;
      if (cfg_we) begin
        act <= 1'b0;
      end else if (mode_sync) begin
        if (!cs_n) begin
          if (!load_n) begin
            baddr <= addr_in;
            cyc   <= rd_sel ? CYC_READ : CYC_WRITE;
            act   <= 1'b1;
          end else if (!step_n && act) begin
            baddr <= stepped;
          end
        end
      end else begin
        act <= 1'b0;
        cyc <= CYC_READ;
        if (new_rd) baddr <= addr_in;
      end
    end
  end

  // R2: a load in synchronous mode opens a burst at the pin address
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_sync && !cfg_we && !cs_n && !load_n) |=> (act && baddr == $past(addr_in)));

  // R3: a held step leaves the address alone
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_sync && !cfg_we && !cs_n && load_n && step_n) |=> $stable(baddr));

  // R3: stepping never leaves the aligned window
  p_window_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_sync && !cfg_we && !cs_n && load_n) |=>
      ((baddr & ~$past(mask)) == ($past(baddr) & ~$past(mask))));

  // R9: without a new read cycle the asynchronous address holds
  p_async_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (!mode_sync && !cfg_we && !new_rd) |=> $stable(baddr));
endmodule

// File: rtl/bmf_out_ctl.sv
module bmf_out_ctl #(
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_sync,
  input  logic           cfg_we,
  input  logic           cs_n,
  input  logic           rd_en_n,
  input  logic           hiz_n,
  input  logic           wen_n,
  input  logic           act,
  input  bmf_pkg::cyc_e  cyc,
  input  logic [DW-1:0]  rdata,
  output logic           sync_rd,
  output logic           dq_oe,
  output logic [DW-1:0]  dq_out
);
  import bmf_pkg::*;

  logic          oe_q;
  logic [DW-1:0] dq_q;
  logic          async_oe;

  assign sync_rd  = mode_sync && !cfg_we && !cs_n && !rd_en_n && hiz_n && act && (cyc == CYC_READ);
  assign async_oe = !cs_n && !rd_en_n && hiz_n && wen_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b0;
      dq_q <= '0;
    end else begin
      oe_q <= sync_rd;
      if (sync_rd) dq_q <= rdata;
    end
  end

  always_comb begin
    if (rst)            dq_oe = 1'b0;
    else if (mode_sync) dq_oe = oe_q;
    else                dq_oe = async_oe;
    dq_out = mode_sync ? dq_q : rdata;
  end

  // R4: an enabled synchronous read drives the captured word one edge later
  p_sync_data_r4: assert property (@(posedge clk) disable iff (rst)
    sync_rd |=> (dq_oe && dq_out == $past(rdata)));

  // R5: a sampled output disable wins over output enable
  p_od_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_sync && !cfg_we && !hiz_n) |=> !dq_oe);

  // R6: asynchronous output disable releases the bus in the same cycle
  p_async_od_r6: assert property (@(posedge clk) disable iff (rst)
    (!mode_sync && !hiz_n) |-> !dq_oe);
endmodule

// File: rtl/bmf_rw_ctl.sv
module bmf_rw_ctl #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_sync,
  input  logic           cfg_we,
  input  logic           cs_n,
  input  logic           wen_n,
  input  logic           load_n,
  input  logic           act,
  input  bmf_pkg::cyc_e  cyc,
  input  logic           sync_rd,
  input  logic [AW-1:0]  baddr,
  input  logic [AW-1:0]  addr_in,
  input  logic [DW-1:0]  wdata,
  output logic           arr_we,
  output logic [AW-1:0]  arr_waddr,
  output logic [DW-1:0]  arr_wdata,
  output logic           arr_rd
);
  import bmf_pkg::*;

  logic sync_wr;
  logic async_wr;
  logic async_rd;

  assign sync_wr  = mode_sync && !cfg_we && !cs_n && !wen_n && load_n && act && (cyc == CYC_WRITE);
  assign async_wr = !mode_sync && !cfg_we && !cs_n && !wen_n;
  assign async_rd = !mode_sync && !cfg_we && !cs_n && wen_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we    <= 1'b0;
      arr_rd    <= 1'b0;
      arr_waddr <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we <= sync_wr || async_wr;
      arr_rd <= sync_rd || async_rd;
      if (sync_wr || async_wr) begin
        arr_waddr <= sync_wr ? baddr : addr_in;
        arr_wdata <= wdata;
      end
    end
  end

  // R7: a deselected device makes no array access
  p_cs_idle_r7: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!arr_we && !arr_rd));

  // R8: a synchronous burst write lands at the burst address
  p_sync_wr_r8: assert property (@(posedge clk) disable iff (rst)
    sync_wr |=> (arr_we && arr_waddr == $past(baddr) && arr_wdata == $past(wdata)));

  // R11: an asynchronous write uses the pin address
  p_async_wr_r11: assert property (@(posedge clk) disable iff (rst)
    async_wr |=> (arr_we && arr_waddr == $past(addr_in)));
endmodule

// File: rtl/burst_mem_front.sv
module burst_mem_front #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          pd_rst,
  input  logic          cfg_we,
  input  logic          cfg_sync,
  input  logic          cfg_wrap8,
  input  logic          cs_n,
  input  logic          rd_en_n,
  input  logic          hiz_n,
  input  logic          wen_n,
  input  logic          load_n,
  input  logic          rd_sel,
  input  logic          step_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] arr_addr,
  output logic          arr_rd,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [DW-1:0] arr_wdata,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out
);
  import bmf_pkg::*;

  logic          mode_sync;
  logic          wrap8;
  logic          act;
  cyc_e          cyc;
  logic          sync_rd;
  logic [AW-1:0] baddr;

  always_ff @(posedge clk) begin
    if (pd_rst) begin
      mode_sync <= 1'b0;
      wrap8     <= 1'b0;
    end else if (cfg_we) begin
      mode_sync <= cfg_sync;
      wrap8     <= cfg_wrap8;
    end
  end

  bmf_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst(pd_rst), .mode_sync(mode_sync), .wrap8(wrap8),
    .cfg_we(cfg_we), .cs_n(cs_n), .wen_n(wen_n), .load_n(load_n),
    .rd_sel(rd_sel), .step_n(step_n), .addr_in(addr_in),
    .baddr(baddr), .act(act), .cyc(cyc)
  );

  bmf_out_ctl #(.DW(DW)) u_out (
    .clk(clk), .rst(pd_rst), .mode_sync(mode_sync), .cfg_we(cfg_we),
    .cs_n(cs_n), .rd_en_n(rd_en_n), .hiz_n(hiz_n), .wen_n(wen_n),
    .act(act), .cyc(cyc), .rdata(rdata), .sync_rd(sync_rd),
    .dq_oe(dq_oe), .dq_out(dq_out)
  );

  bmf_rw_ctl #(.AW(AW), .DW(DW)) u_rw (
    .clk(clk), .rst(pd_rst), .mode_sync(mode_sync), .cfg_we(cfg_we),
    .cs_n(cs_n), .wen_n(wen_n), .load_n(load_n), .act(act), .cyc(cyc),
    .sync_rd(sync_rd), .baddr(baddr), .addr_in(addr_in), .wdata(wdata),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_rd(arr_rd)
  );

  assign arr_addr = baddr;

  // R1: reset leaves no access pending and the mode asynchronous
  p_reset_idle_r1: assert property (@(posedge clk)
    pd_rst |=> (!arr_we && !arr_rd && !mode_sync && !wrap8));

  // R10: a configuration write takes the pin values
  p_cfg_load_r10: assert property (@(posedge clk) disable iff (pd_rst)
    cfg_we |=> (mode_sync == $past(cfg_sync) && wrap8 == $past(cfg_wrap8)));
endmodule

// File: tb/burst_mem_front_tb_top.sv
module burst_mem_front_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic pd_rst = 1'b1, cfg_we = 1'b0, cfg_sync = 1'b0, cfg_wrap8 = 1'b0;
  logic cs_n = 1'b1, rd_en_n = 1'b1, hiz_n = 1'b1, wen_n = 1'b1;
  logic load_n = 1'b1, rd_sel = 1'b1, step_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [AW-1:0] arr_addr, arr_waddr;
  logic [DW-1:0] arr_wdata, dq_out;
  logic arr_rd, arr_we, dq_oe;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  assign rdata = mem[arr_addr];
  always @(posedge clk) if (arr_we) mem[arr_waddr] <= arr_wdata;

  burst_mem_front #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .pd_rst(pd_rst), .cfg_we(cfg_we), .cfg_sync(cfg_sync),
    .cfg_wrap8(cfg_wrap8), .cs_n(cs_n), .rd_en_n(rd_en_n), .hiz_n(hiz_n),
    .wen_n(wen_n), .load_n(load_n), .rd_sel(rd_sel), .step_n(step_n),
    .addr_in(addr_in), .wdata(wdata), .rdata(rdata), .arr_addr(arr_addr),
    .arr_rd(arr_rd), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .dq_oe(dq_oe), .dq_out(dq_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit m_sync, m_w8, m_act, m_wr, m_csp, m_ldp, m_oeq, m_we, m_rd;
  logic [AW-1:0] m_addr, m_wa;
  logic [DW-1:0] m_dq, m_wd;

  function automatic logic [AW-1:0] wrap_step(logic [AW-1:0] a, bit w8);
    logic [AW-1:0] msk = w8 ? AW'(7) : AW'(3);
    return (a & ~msk) | ((a + AW'(1)) & msk);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act_v, logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // advance the model across one rising edge using the pins set for it
  task automatic model_edge();
    bit rdc, swr, awr, ard, nrd;
    if (pd_rst) begin
      m_sync = 0; m_w8 = 0; m_act = 0; m_wr = 0; m_csp = 1; m_ldp = 1;
      m_oeq = 0; m_we = 0; m_rd = 0; m_addr = '0; m_wa = '0; m_dq = '0; m_wd = '0;
      return;
    end
    rdc = m_sync && !cfg_we && !cs_n && !rd_en_n && hiz_n && m_act && !m_wr;
    swr = m_sync && !cfg_we && !cs_n && !wen_n && load_n && m_act && m_wr;
    awr = !m_sync && !cfg_we && !cs_n && !wen_n;
    ard = !m_sync && !cfg_we && !cs_n && wen_n;
    nrd = !cs_n && wen_n && (m_csp || (m_ldp && !load_n));
    m_oeq = rdc;
    if (rdc) m_dq = mem[m_addr];
    m_we = swr || awr;
    m_rd = rdc || ard;
    if (swr) begin m_wa = m_addr; m_wd = wdata; end
    if (awr) begin m_wa = addr_in; m_wd = wdata; end
    if (cfg_we) begin
      m_act = 0;
    end else if (m_sync) begin
      if (!cs_n) begin
        if (!load_n) begin m_addr = addr_in; m_wr = !rd_sel; m_act = 1; end
        else if (!step_n && m_act) m_addr = wrap_step(m_addr, m_w8);
      end
    end else begin
      m_act = 0; m_wr = 0;
      if (nrd) m_addr = addr_in;
    end
    if (cfg_we) begin m_sync = cfg_sync; m_w8 = cfg_wrap8; end
    m_csp = cs_n; m_ldp = load_n;
  endtask

  // pins must already be set; runs one edge and compares all outputs
  task automatic cycle();
    bit exp_oe;
    model_edge();
    @(posedge clk);
    #1;
    chk(arr_addr == m_addr, "R2/R3/R9 addr", 64'(arr_addr), 64'(m_addr));
    chk(arr_we == m_we, "R8/R11 we", 64'(arr_we), 64'(m_we));
    if (m_we) begin
      chk(arr_waddr == m_wa, "R8/R11 waddr", 64'(arr_waddr), 64'(m_wa));
      chk(arr_wdata == m_wd, "R8/R11 wdata", 64'(arr_wdata), 64'(m_wd));
    end
    chk(arr_rd == m_rd, "R4/R11 rd", 64'(arr_rd), 64'(m_rd));
    exp_oe = pd_rst ? 1'b0 : (m_sync ? m_oeq : (!cs_n && !rd_en_n && hiz_n && wen_n));
    chk(dq_oe == exp_oe, "R4/R5/R6 oe", 64'(dq_oe), 64'(exp_oe));
    if (exp_oe && dq_oe) begin
      if (m_sync) chk(dq_out == m_dq, "R4 data", 64'(dq_out), 64'(m_dq));
      else        chk(dq_out == mem[m_addr], "R6 data", 64'(dq_out), 64'(mem[m_addr]));
    end
    @(negedge clk);
  endtask

  task automatic idle_pins();
    cfg_we = 0; cs_n = 1; rd_en_n = 1; hiz_n = 1; wen_n = 1;
    load_n = 1; rd_sel = 1; step_n = 1;
  endtask

  task automatic set_cfg(bit s, bit w8);
    idle_pins(); cfg_we = 1; cfg_sync = s; cfg_wrap8 = w8; cycle(); cfg_we = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = (32'(i) * 32'h01010101) ^ 32'hA5C30000;
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: reset state
    pd_rst = 1; cs_n = 0; rd_en_n = 0; cycle(); cycle();
    chk(dq_oe == 0 && arr_we == 0 && arr_rd == 0 && arr_addr == 0, "R1 reset idle",
        {60'd0, dq_oe, arr_we, arr_rd, |arr_addr}, 64'd0);
    pd_rst = 0; idle_pins(); cycle();

    // R10/R9: after reset the mode is asynchronous; a read opens and latches the address
    addr_in = 8'h21; cs_n = 0; rd_en_n = 0; cycle();
    chk(arr_addr == 8'h21 && dq_oe, "R10 async after reset", 64'(arr_addr), 64'h21);
    addr_in = 8'h35; cycle();
    chk(arr_addr == 8'h21, "R9 address held without load fall", 64'(arr_addr), 64'h21);
    load_n = 0; cycle();
    chk(arr_addr == 8'h35, "R9 load fall opens new read", 64'(arr_addr), 64'h35);
    addr_in = 8'h44; cycle();
    chk(arr_addr == 8'h35, "R9 steady low load ignored", 64'(arr_addr), 64'h35);
    hiz_n = 0; #1;
    chk(dq_oe == 0, "R6 disable releases at once", 64'(dq_oe), 64'd0);
    cycle(); hiz_n = 1; load_n = 1;
    wen_n = 0; addr_in = 8'h50; wdata = 32'hDEAD0050; cycle();
    chk(arr_we && arr_waddr == 8'h50, "R11 async write", 64'(arr_waddr), 64'h50);

    // synchronous, window 4
    set_cfg(1, 0);
    cs_n = 0; load_n = 0; rd_sel = 1; addr_in = 8'h0D; cycle();
    chk(arr_addr == 8'h0D, "R2 sync load", 64'(arr_addr), 64'h0D);
    load_n = 1; step_n = 0; cycle(); cycle();
    chk(arr_addr == 8'h0F, "R3 step", 64'(arr_addr), 64'h0F);
    cycle();
    chk(arr_addr == 8'h0C, "R3 wrap in window 4", 64'(arr_addr), 64'h0C);
    step_n = 1; cycle();
    chk(arr_addr == 8'h0C, "R3 hold", 64'(arr_addr), 64'h0C);
    rd_en_n = 0; cycle();
    chk(dq_oe && dq_out == mem[8'h0C], "R4 sync read data", 64'(dq_out), 64'(mem[8'h0C]));
    hiz_n = 0; cycle();
    chk(dq_oe == 0, "R5 disable beats enable", 64'(dq_oe), 64'd0);
    hiz_n = 1; cs_n = 1; load_n = 0; addr_in = 8'h77; cycle();
    chk(arr_addr == 8'h0C && !arr_rd, "R7 deselected no load", 64'(arr_addr), 64'h0C);
    // write burst
    cs_n = 0; rd_en_n = 1; load_n = 0; rd_sel = 0; addr_in = 8'h92; cycle();
    load_n = 1; wen_n = 0; step_n = 0; wdata = 32'h12345678; cycle();
    chk(arr_we && arr_waddr == 8'h92 && arr_wdata == 32'h12345678, "R8 sync write",
        64'(arr_waddr), 64'h92);
    wen_n = 1; step_n = 1;
    // window 8
    set_cfg(1, 1);
    cs_n = 0; load_n = 0; rd_sel = 1; addr_in = 8'h17; cycle();
    load_n = 1; step_n = 0; cycle();
    chk(arr_addr == 8'h10, "R3 wrap in window 8", 64'(arr_addr), 64'h10);
    idle_pins();

    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      pd_rst   = ($urandom_range(0, 299) == 0);
      cfg_we   = ($urandom_range(0, 79) == 0);
      cfg_sync = $urandom_range(0, 3) != 0;
      cfg_wrap8 = $urandom_range(0, 1);
      cs_n     = ($urandom_range(0, 9) == 0);
      rd_en_n  = ($urandom_range(0, 3) == 0);
      hiz_n    = ($urandom_range(0, 7) != 0);
      wen_n    = ($urandom_range(0, 2) != 0);
      load_n   = ($urandom_range(0, 5) != 0);
      rd_sel   = $urandom_range(0, 1);
      step_n   = ($urandom_range(0, 2) == 0);
      addr_in  = AW'($urandom);
      wdata    = $urandom;
      cycle();
      if (!pd_rst && !dq_oe && !hiz_n) chk(1'b1, "R5/R6", 0, 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule